// File: doc/BRIEF.md
# Event Notification and Escalation Engine

This block takes one event trigger at a time and walks it through a notification and escalation flow. Each trigger addresses one entry of a descriptor table. The entry says how the event is to be coalesced, which virtual-thread target the presenter should be asked about, whether a missed delivery is recorded as pending, and whether the event escalates to another descriptor. The descriptor table and the target table sit outside the block. The block reads both through combinational lookup ports and issues single-entry write strobes when state changes.

Each descriptor carries two independent two-bit coalescing pairs, written {P,Q}: one gates notification and one gates escalation. A step on a pair applies a fixed rule. That rule decides whether the event moves on, and the pair is written back only when the step changed it. A descriptor can be silent, which skips notification and goes straight to escalation. It can also escalate unconditionally, which bypasses the escalation pair. When the presenter finds no matching thread, backlog recording ORs the priority's bit into the target's pending-priority byte. An escalation re-enters the flow once, at the descriptor named in the current entry and with that entry's escalation data.

Top module: `eqnEngine`

## Requirements
- R1: `trigReady` is high exactly when no trigger is in progress, including during and right after reset. A trigger is taken on a clock edge where `trigValid` and `trigReady` are both high, and `trigReady` stays low until every step caused by that trigger has finished.
- R2: A descriptor with `silent` set makes no presenter request and leaves its notification pair unchanged. Processing goes directly to the escalation step.
- R3: When `notifyOn` is clear, the notification pair `esn` is stepped before the presenter is asked. Encoded as {P,Q}: 00 becomes 10 and the event goes on. 10 and 11 become 11 and processing ends. 01 stays 01 and processing ends. The descriptor is written back only when the pair changed.
- R4: When `notifyOn` is set, the notification pair is neither consulted nor written.
- R5: If the target entry named by `nvtBlk`/`nvtIdx` has its valid bit clear, `errValid` pulses with `errCode` 1. No presenter request follows and processing ends.
- R6: The presenter request carries the descriptor's `fmt`, `nvtBlk`, `nvtIdx` and `prio` together with the event data. `presReq` and these fields hold steady until `presAck`.
- R7: An acknowledgement with `presHit` high ends processing. No target-table write and no escalation follow.
- R8: On a miss with `backlog` set and `fmt` 0, the target entry is rewritten with bit (7 − prio) ORed into its 8-bit pending byte. A priority of 8 or more adds no bit.
- R9: On a miss with `backlog` set and `fmt` 1, `errValid` pulses with `errCode` 2. The target table is not written and no escalation follows.
- R10: Escalation happens only when `escalate` is set. Unless `uncond` is set, the escalation pair `ese` is first stepped with the R3 rule and written back only if it changed. Only a result of "go on" lets the escalation proceed.
- R11: An escalation restarts the flow at descriptor {`escBlk`,`escIdx`}, and `escData` becomes the event data. Only one hop is taken per trigger: the escalated descriptor's own escalation step is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger offered |
| trigReady | output | 1 | Engine idle, trigger can be taken |
| trigBlk | input | 2 | Descriptor block of the trigger |
| trigIdx | input | 4 | Descriptor index of the trigger |
| trigData | input | 16 | Event data of the trigger |
| descRdAddr | output | 6 | Descriptor lookup address {blk,idx} |
| descRdData | input | 42 | Descriptor contents at `descRdAddr` (same cycle) |
| descWrEn | output | 1 | Descriptor write strobe |
| descWrAddr | output | 6 | Descriptor write address |
| descWrData | output | 42 | Descriptor write data |
| nvtRdAddr | output | 6 | Target-table lookup address |
| nvtRdData | input | 9 | Target entry {valid, pending byte} (same cycle) |
| nvtWrEn | output | 1 | Target-table write strobe |
| nvtWrAddr | output | 6 | Target-table write address |
| nvtWrData | output | 9 | Target-table write data |
| presReq | output | 1 | Presenter request |
| presFmt | output | 1 | Request format (0 specific target, 1 logical server) |
| presBlk | output | 2 | Target block |
| presIdx | output | 4 | Target index |
| presPrio | output | 4 | Event priority |
| presData | output | 16 | Event data |
| presAck | input | 1 | Presenter response valid |
| presHit | input | 1 | Presenter found a matching thread |
| errValid | output | 1 | Configuration error pulse |
| errCode | output | 2 | 1 invalid target, 2 backlog with format 1 |

## Verification
The assertions assume that both tables answer lookups in the same cycle and change only through the block's own write strobes. They also assume that the presenter raises `presAck` only while `presReq` is high, and that it holds `presAck` for one cycle. The bench models both tables as arrays that are read combinationally and updated on the write strobes. It answers each request half a cycle after it appears and drops the acknowledgement on the next falling edge, so these conditions hold throughout the stimulus.

// File: rtl/eqnPkg.sv
package eqnPkg;
  parameter int BLK_W  = 2;
  parameter int IDX_W  = 4;
  parameter int DATA_W = 16;
  parameter int PRIO_W = 4;
  parameter int IPB_W  = 8;
  localparam int ADDR_W = BLK_W + IDX_W;

  typedef struct packed {
    logic              silent;
    logic              notifyOn;
    logic              backlog;
    logic              escalate;
    logic              uncond;
    logic              fmt;
    logic [1:0]        esn;
    logic [1:0]        ese;
    logic [PRIO_W-1:0] prio;
    logic [BLK_W-1:0]  nvtBlk;
    logic [IDX_W-1:0]  nvtIdx;
    logic [BLK_W-1:0]  escBlk;
    logic [IDX_W-1:0]  escIdx;
    logic [DATA_W-1:0] escData;
  } descT;

  localparam int DESC_W = $bits(descT);

  typedef struct packed {
    logic             valid;
    logic [IPB_W-1:0] ipb;
  } nvtT;

  localparam int NVT_W = $bits(nvtT);

  typedef struct packed {
    logic fwd;
    logic [1:0] next;
  } pqStepT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTrig;
    logic loadEsc;
    logic stepEsn;
    logic stepEse;
    logic wrNvt;
  } strobeT;

  // status from datapath to control
  typedef struct packed {
    logic silent;
    logic notifyOn;
    logic fwdN;
    logic nvtValid;
    logic backlog;
    logic fmt1;
    logic escalate;
    logic uncond;
    logic fwdE;
    logic hop;
  } statusT;

  function automatic pqStepT pqStep(input logic [1:0] pq);
    pqStepT r;
    case (pq)
      2'b00:   begin r.fwd = 1'b1; r.next = 2'b10; end
      2'b01:   begin r.fwd = 1'b0; r.next = 2'b01; end
      default: begin r.fwd = 1'b0; r.next = 2'b11; end
    endcase
    return r;
  endfunction

  function automatic logic [IPB_W-1:0] prioBit(input logic [PRIO_W-1:0] p);
    logic [IPB_W-1:0] r;
    r = '0;
    for (int i = 0; i < IPB_W; i++)
      if (32'(p) == i) r[IPB_W-1-i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/eqnCtrl.sv
module eqnCtrl
  import eqnPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   trigValid,
  input  logic   presAck,
  input  logic   presHit,
  input  statusT st,
  output strobeT stb,
  output logic   busy,
  output logic   presReq,
  output logic   errValid,
  output logic [1:0] errCode
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_TARGET, S_PRESENT, S_ESC} stateT;
  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    errValid  = 1'b0;
    errCode   = 2'd0;
    presReq   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (trigValid) begin
          stb.loadTrig = 1'b1;
          stateNext    = S_EVAL;
        end
      end
      S_EVAL: begin
        if (st.silent) begin
          stateNext = S_ESC;
        end else if (!st.notifyOn) begin
          stb.stepEsn = 1'b1;
          stateNext   = st.fwdN ? S_TARGET : S_IDLE;
        end else begin
          stateNext = S_TARGET;
        end
      end
      S_TARGET: begin
        if (!st.nvtValid) begin
          errValid  = 1'b1;
          errCode   = 2'd1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_PRESENT;
        end
      end
      S_PRESENT: begin
        presReq = 1'b1;
        if (presAck) begin
          if (presHit) begin
            stateNext = S_IDLE;
          end else if (st.backlog && st.fmt1) begin
            errValid  = 1'b1;
            errCode   = 2'd2;
            stateNext = S_IDLE;
          end else begin
            stb.wrNvt = st.backlog;
            stateNext = S_ESC;
          end
        end
      end
      S_ESC: begin
        if (!st.escalate || st.hop) begin
          stateNext = S_IDLE;
        end else if (st.uncond) begin
          stb.loadEsc = 1'b1;
          stateNext   = S_EVAL;
        end else begin
          stb.stepEse = 1'b1;
          stb.loadEsc = st.fwdE;
          stateNext   = st.fwdE ? S_EVAL : S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/eqnPath.sv
module eqnPath
  import eqnPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [BLK_W-1:0]  trigBlk,
  input  logic [IDX_W-1:0]  trigIdx,
  input  logic [DATA_W-1:0] trigData,
  input  descT              desc,
  input  nvtT               nvtRd,
  output statusT            st,
  output logic [ADDR_W-1:0] curAddr,
  output logic              descWrEn,
  output descT              descWr,
  output logic [ADDR_W-1:0] nvtAddr,
  output logic              nvtWrEn,
  output nvtT               nvtWr,
  output logic [DATA_W-1:0] curData
);
  logic   hop;
  pqStepT esnStep, eseStep;
  logic   esnChanged, eseChanged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curData <= '0;
      hop     <= 1'b0;
    end else if (stb.loadTrig) begin
      curAddr <= {trigBlk, trigIdx};
      curData <= trigData;
      hop     <= 1'b0;
    end else if (stb.loadEsc) begin
      curAddr <= {desc.escBlk, desc.escIdx};
      curData <= desc.escData;
      hop     <= 1'b1;
    end
  end

  assign esnStep    = pqStep(desc.esn);
  assign eseStep    = pqStep(desc.ese);
  assign esnChanged = (esnStep.next != desc.esn);
  assign eseChanged = (eseStep.next != desc.ese);

  always_comb begin
    descWr = desc;
    if (stb.stepEsn) descWr.esn = esnStep.next;
    if (stb.stepEse) descWr.ese = eseStep.next;
  end
  assign descWrEn = (stb.stepEsn && esnChanged) || (stb.stepEse && eseChanged);

  assign nvtAddr   = {desc.nvtBlk, desc.nvtIdx};
  assign nvtWrEn   = stb.wrNvt;
  assign nvtWr.valid = nvtRd.valid;
  assign nvtWr.ipb   = nvtRd.ipb | prioBit(desc.prio);

  always_comb begin
    st.silent   = desc.silent;
    st.notifyOn = desc.notifyOn;
    st.fwdN     = esnStep.fwd;
    st.nvtValid = nvtRd.valid;
    st.backlog  = desc.backlog;
    st.fmt1     = desc.fmt;
    st.escalate = desc.escalate;
    st.uncond   = desc.uncond;
    st.fwdE     = eseStep.fwd;
    st.hop      = hop;
  end
endmodule

// File: rtl/eqnEngine.sv
module eqnEngine
  import eqnPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigValid,
  output logic              trigReady,
  input  logic [BLK_W-1:0]  trigBlk,
  input  logic [IDX_W-1:0]  trigIdx,
  input  logic [DATA_W-1:0] trigData,
  output logic [ADDR_W-1:0] descRdAddr,
  input  logic [DESC_W-1:0] descRdData,
  output logic              descWrEn,
  output logic [ADDR_W-1:0] descWrAddr,
  output logic [DESC_W-1:0] descWrData,
  output logic [ADDR_W-1:0] nvtRdAddr,
  input  logic [NVT_W-1:0]  nvtRdData,
  output logic              nvtWrEn,
  output logic [ADDR_W-1:0] nvtWrAddr,
  output logic [NVT_W-1:0]  nvtWrData,
  output logic              presReq,
  output logic              presFmt,
  output logic [BLK_W-1:0]  presBlk,
  output logic [IDX_W-1:0]  presIdx,
  output logic [PRIO_W-1:0] presPrio,
  output logic [DATA_W-1:0] presData,
  input  logic              presAck,
  input  logic              presHit,
  output logic              errValid,
  output logic [1:0]        errCode
);
  strobeT stb;
  statusT st;
  logic   busy;
  descT   desc, descWr;
  nvtT    nvtRd, nvtWr;
  logic [ADDR_W-1:0] curAddr, nvtAddr;

  assign desc  = descT'(descRdData);
  assign nvtRd = nvtT'(nvtRdData);

  eqnCtrl uCtrl (
    .clk, .rstN,
    .trigValid, .presAck, .presHit,
    .st, .stb, .busy, .presReq, .errValid, .errCode
  );

  eqnPath uPath (
    .clk, .rstN, .stb,
    .trigBlk, .trigIdx, .trigData,
    .desc, .nvtRd, .st, .curAddr,
    .descWrEn, .descWr, .nvtAddr, .nvtWrEn, .nvtWr,
    .curData(presData)
  );

  assign trigReady  = !busy;
  assign descRdAddr = curAddr;
  assign descWrAddr = curAddr;
  assign descWrData = descWr;
  assign nvtRdAddr  = nvtAddr;
  assign nvtWrAddr  = nvtAddr;
  assign nvtWrData  = nvtWr;
  assign presFmt    = desc.fmt;
  assign presBlk    = desc.nvtBlk;
  assign presIdx    = desc.nvtIdx;
  assign presPrio   = desc.prio;
endmodule

// File: rtl/eqnEngineChk.sv
module eqnEngineChk
  import eqnPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              trigReady,
  input logic [ADDR_W-1:0] descRdAddr,
  input logic [DESC_W-1:0] descRdData,
  input logic              descWrEn,
  input logic [ADDR_W-1:0] descWrAddr,
  input logic [DESC_W-1:0] descWrData,
  input logic [ADDR_W-1:0] nvtRdAddr,
  input logic [NVT_W-1:0]  nvtRdData,
  input logic              nvtWrEn,
  input logic [ADDR_W-1:0] nvtWrAddr,
  input logic [NVT_W-1:0]  nvtWrData,
  input logic              presReq,
  input logic              presAck,
  input logic [PRIO_W-1:0] presPrio,
  input logic [BLK_W-1:0]  presBlk,
  input logic [IDX_W-1:0]  presIdx,
  input logic              errValid
);
  descT rdD, wrD;
  nvtT  rdN, wrN;
  assign rdD = descT'(descRdData);
  assign wrD = descT'(descWrData);
  assign rdN = nvtT'(nvtRdData);
  assign wrN = nvtT'(nvtWrData);

  // R1
  ready_no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigReady |-> !presReq && !descWrEn && !nvtWrEn);

  // R3
  desc_write_changes_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |-> (descWrAddr == descRdAddr) &&
                 ((wrD.esn != rdD.esn) || (wrD.ese != rdD.ese)) &&
                 (wrD.prio == rdD.prio) && (wrD.escData == rdD.escData));

  // R6
  request_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    presReq && !presAck |=> presReq && $stable(presPrio) && $stable(presBlk) && $stable(presIdx));

  // R8
  backlog_or_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    nvtWrEn |-> (nvtWrAddr == nvtRdAddr) && ((wrN.ipb & rdN.ipb) == rdN.ipb) &&
                ($countones(wrN.ipb & ~rdN.ipb) <= 1) && !descWrEn);

  // R5
  error_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> trigReady);
endmodule

bind eqnEngine eqnEngineChk uChk (.*);

// File: tb/sim_eqnEngine.sv
`timescale 1ns/1ps
module sim_eqnEngine;
  import eqnPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic trigValid = 1'b0;
  logic trigReady;
  logic [BLK_W-1:0]  trigBlk = '0;
  logic [IDX_W-1:0]  trigIdx = '0;
  logic [DATA_W-1:0] trigData = '0;
  logic [ADDR_W-1:0] descRdAddr, descWrAddr, nvtRdAddr, nvtWrAddr;
  logic [DESC_W-1:0] descRdData, descWrData;
  logic [NVT_W-1:0]  nvtRdData, nvtWrData;
  logic descWrEn, nvtWrEn, presReq, presFmt, errValid;
  logic [BLK_W-1:0]  presBlk;
  logic [IDX_W-1:0]  presIdx;
  logic [PRIO_W-1:0] presPrio;
  logic [DATA_W-1:0] presData;
  logic [1:0] errCode;
  logic presAck = 1'b0;
  logic presHit = 1'b0;
  logic hitCfg  = 1'b0;

  descT descMem [2**ADDR_W];
  nvtT  nvtMem  [2**ADDR_W];
  assign descRdData = descMem[descRdAddr];
  assign nvtRdData  = nvtMem[nvtRdAddr];

  eqnEngine u0 (.*);

  int checks = 0, errors = 0;
  int presCnt = 0, errCnt = 0, descWrCnt = 0, nvtWrCnt = 0;
  int lastErr = 0;
  logic [31:0] presLog [4];

  always @(negedge clk) begin
    if (presReq && !presAck) begin presAck = 1'b1; presHit = hitCfg; end
    else begin presAck = 1'b0; presHit = 1'b0; end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (presReq && presAck) begin
        if (presCnt < 4) presLog[presCnt] <= {presData, 3'b0, presFmt, presPrio, 2'b0, presBlk, presIdx};
        presCnt <= presCnt + 1;
      end
      if (descWrEn) begin descMem[descWrAddr] <= descT'(descWrData); descWrCnt <= descWrCnt + 1; end
      if (nvtWrEn)  begin nvtMem[nvtWrAddr] <= nvtT'(nvtWrData); nvtWrCnt <= nvtWrCnt + 1; end
      if (errValid) begin errCnt <= errCnt + 1; lastErr <= int'(errCode); end
    end
  end

  function automatic logic [31:0] reqWord(logic [DATA_W-1:0] d, logic f, logic [PRIO_W-1:0] p, logic [ADDR_W-1:0] a);
    return {d, 3'b0, f, p, 2'b0, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic descT baseDesc(logic [ADDR_W-1:0] nvtA, logic [PRIO_W-1:0] p);
    descT d;
    d = '0;
    d.prio = p;
    {d.nvtBlk, d.nvtIdx} = nvtA;
    return d;
  endfunction

  task automatic runTrig(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] data, input bit hit);
    int t;
    @(negedge clk);
    presCnt = 0; errCnt = 0; descWrCnt = 0; nvtWrCnt = 0; lastErr = 0;
    hitCfg = hit;
    trigValid = 1'b1; {trigBlk, trigIdx} = a; trigData = data;
    @(negedge clk);
    check(!trigReady, "R1 busy after accept", 64'(trigReady), 0);
    trigValid = 1'b0;
    t = 0;
    while (!trigReady && t < 100) begin @(negedge clk); t++; end
    check(t < 100, "R1 trigger completes", t, 100);
  endtask

  task automatic tNotifyPq();
    descT d;
    d = baseDesc(6'h05, 4'd3);
    descMem[6'h10] = d;
    nvtMem[6'h05] = '{valid: 1'b1, ipb: 8'h00};
    runTrig(6'h10, 16'hABCD, 1'b1);
    check(presCnt == 1, "R3 00 forwards", presCnt, 1);
    check(presLog[0] == reqWord(16'hABCD, 1'b0, 4'd3, 6'h05), "R6 request fields", presLog[0], reqWord(16'hABCD, 1'b0, 4'd3, 6'h05));
    check(descMem[6'h10].esn == 2'b10, "R3 00 to 10", descMem[6'h10].esn, 2'b10);
    check(nvtWrCnt == 0, "R7 hit no backlog", nvtWrCnt, 0);
    runTrig(6'h10, 16'h0001, 1'b1);
    check(presCnt == 0 && descMem[6'h10].esn == 2'b11, "R3 10 to 11 stop", {presCnt, 30'(descMem[6'h10].esn)}, 2'b11);
    runTrig(6'h10, 16'h0002, 1'b1);
    check(presCnt == 0 && descWrCnt == 0, "R3 11 no write", {presCnt, descWrCnt}, 0);
    d.esn = 2'b01;
    descMem[6'h11] = d;
    runTrig(6'h11, 16'h0003, 1'b1);
    check(presCnt == 0 && descWrCnt == 0 && descMem[6'h11].esn == 2'b01, "R3 01 holds", {presCnt, descWrCnt}, 0);
  endtask

  task automatic tNotifyOn();
    descT d;
    d = baseDesc(6'h05, 4'd1);
    d.notifyOn = 1'b1;
    d.esn = 2'b11;
    descMem[6'h12] = d;
    runTrig(6'h12, 16'h1234, 1'b1);
    check(presCnt == 1 && descWrCnt == 0 && descMem[6'h12].esn == 2'b11, "R4 pair untouched", {presCnt, descWrCnt}, 64'h1_0000_0000);
  endtask

  task automatic tBadTarget();
    descT d;
    d = baseDesc(6'h06, 4'd1);
    d.notifyOn = 1'b1;
    descMem[6'h13] = d;
    nvtMem[6'h06] = '{valid: 1'b0, ipb: 8'h00};
    runTrig(6'h13, 16'h0, 1'b1);
    check(errCnt == 1 && lastErr == 1 && presCnt == 0, "R5 invalid target", {errCnt, lastErr}, {32'd1, 32'd1});
  endtask

  task automatic tBacklog();
    descT d;
    d = baseDesc(6'h07, 4'd2);
    d.notifyOn = 1'b1; d.backlog = 1'b1;
    descMem[6'h14] = d;
    nvtMem[6'h07] = '{valid: 1'b1, ipb: 8'h01};
    runTrig(6'h14, 16'h0, 1'b0);
    check(nvtMem[6'h07].ipb == 8'h21 && nvtWrCnt == 1, "R8 ipb bit 5", nvtMem[6'h07].ipb, 8'h21);
    d.prio = 4'd9;
    descMem[6'h14] = d;
    runTrig(6'h14, 16'h0, 1'b0);
    check(nvtMem[6'h07].ipb == 8'h21, "R8 prio 9 no bit", nvtMem[6'h07].ipb, 8'h21);
    d.prio = 4'd0; d.fmt = 1'b1; d.escalate = 1'b1;
    descMem[6'h15] = d;
    runTrig(6'h15, 16'h0, 1'b0);
    check(errCnt == 1 && lastErr == 2 && nvtWrCnt == 0 && descMem[6'h15].ese == 2'b00, "R9 fmt1 backlog", {errCnt, lastErr}, {32'd1, 32'd2});
  endtask

  task automatic tEscalate();
    descT d, tgt;
    tgt = baseDesc(6'h09, 4'd4);
    tgt.notifyOn = 1'b1; tgt.escalate = 1'b1; tgt.uncond = 1'b1;
    {tgt.escBlk, tgt.escIdx} = 6'h20;
    descMem[6'h21] = tgt;
    descMem[6'h20] = baseDesc(6'h0A, 4'd5);
    nvtMem[6'h09] = '{valid: 1'b1, ipb: 8'h00};
    nvtMem[6'h0A] = '{valid: 1'b1, ipb: 8'h00};
    d = baseDesc(6'h05, 4'd6);
    d.silent = 1'b1; d.escalate = 1'b1; d.esn = 2'b00;
    {d.escBlk, d.escIdx} = 6'h21; d.escData = 16'h5A5A;
    descMem[6'h16] = d;
    runTrig(6'h16, 16'h1111, 1'b0);
    check(descMem[6'h16].esn == 2'b00, "R2 silent skips pair", descMem[6'h16].esn, 0);
    check(descMem[6'h16].ese == 2'b10, "R10 ese 00 to 10", descMem[6'h16].ese, 2'b10);
    check(presCnt == 1 && presLog[0] == reqWord(16'h5A5A, 1'b0, 4'd4, 6'h09), "R11 escalated request", presLog[0], reqWord(16'h5A5A, 1'b0, 4'd4, 6'h09));
    runTrig(6'h16, 16'h1111, 1'b0);
    check(presCnt == 0 && descMem[6'h16].ese == 2'b11, "R10 ese 10 stops", presCnt, 0);
    d.silent = 1'b0; d.notifyOn = 1'b1; d.uncond = 1'b1; d.ese = 2'b11;
    descMem[6'h17] = d;
    runTrig(6'h17, 16'h2222, 1'b0);
    check(presCnt == 2 && presLog[0] == reqWord(16'h2222, 1'b0, 4'd6, 6'h05) && presLog[1] == reqWord(16'h5A5A, 1'b0, 4'd4, 6'h09),
          "R11 uncond two requests one hop", presCnt, 2);
    check(descMem[6'h17].ese == 2'b11 && descWrCnt == 0, "R10 uncond no pair write", descWrCnt, 0);
    d.escalate = 1'b0;
    descMem[6'h18] = d;
    runTrig(6'h18, 16'h3333, 1'b0);
    check(presCnt == 1, "R10 no escalate bit", presCnt, 1);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 2**ADDR_W; i++) begin descMem[i] = '0; nvtMem[i] = '0; end
    repeat (3) @(negedge clk);
    check(trigReady && !presReq && !descWrEn && !nvtWrEn && !errValid, "R1 reset state", {trigReady, presReq, errValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    tNotifyPq();
    tNotifyOn();
    tBadTarget();
    tBacklog();
    tEscalate();
    finishRun();
  end
endmodule